// File: doc/BRIEF.md
# Received Frame Type Status Encoder

This block watches the byte stream of each received Ethernet frame. It picks out the first destination byte, up to two VLAN tags and the effective Length/Type field. At the end of the frame it reports one 3-bit status code.

Several attributes can hold for the same frame. The block reports only the one that ranks highest in a fixed order, and that order does not follow the numeric value of the codes. Two attributes come from outside the block rather than from the header: whether the frame length is legal, and whether an earlier stage recognised a standard or priority flow-control frame. Both are sampled on the end-of-frame beat.

The stream carries one byte per accepted beat. Beats with the valid input low are ignored. The code is registered, and the status strobe rises for exactly one cycle after the accepted end-of-frame beat.

Top module: `frame_status_enc`

## Requirements
- R1: `stat_valid` is high for exactly one cycle, the cycle after an accepted beat that has `in_eof` high. It is low at all other times, and `stat_code` is meaningful only while `stat_valid` is high.
- R2: Code 5 is reported, ahead of every other code, when the first tag TPID (bytes 12-13) is 0x88A8, or when a 0x8100 tag is followed directly by a second tag.
- R3: Code 4 is reported when `in_fc_flag` is high on the end-of-frame beat, unless R2 applies.
- R4: Code 7 is reported when the effective Length/Type is 0x8808, unless R2 or R3 applies.
- R5: Code 6 is reported when `in_len_ok` is low on the end-of-frame beat, unless R2, R3 or R4 applies.
- R6: Code 1 is reported when the effective Length/Type is 0x0600 or greater and is neither 0x8808 nor 0x88F7, unless a higher code applies.
- R7: Code 2 is reported when bit 0 of destination byte 0 is 1 (broadcast or multicast), unless a higher code applies.
- R8: Code 3 is reported when the effective Length/Type is 0x88F7, unless a higher code applies.
- R9: Code 0 is reported when no other attribute holds. This means a legal length, a unicast destination and a Length/Type below 0x0600.
- R10: A single 0x8100 tag moves the effective Length/Type to bytes 16-17. The tag value itself is never taken as a Length/Type.
- R11: Beats with `in_valid` low change neither the parse state nor the result.
- R12: A frame that ends before its Length/Type field is complete has no type attribute. It can therefore report only codes 5, 4, 6, 2 or 0.
- R13: While reset is asserted and after it is released, `stat_valid` stays low until the first end-of-frame beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Beat carries a byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_data | input | 8 | Frame byte |
| in_len_ok | input | 1 | Frame length is legal (sampled at end of frame) |
| in_fc_flag | input | 1 | Standard or priority flow-control frame (sampled at end of frame) |
| stat_valid | output | 1 | Status strobe |
| stat_code | output | 3 | Status code |

## Verification
The embedded assertions check four behaviours on every cycle:
- the one-cycle status strobe after each end-of-frame beat;
- the dominance of a stacked tag, and then of the flow-control flag;
- that code 0 never appears for an illegal length;
- that a resolved Length/Type stays put until the next frame starts.

The rest of the ordering can only be shown by the directed frames, and so can tag skipping, short frames and idle bubbles. Each of those frames sets a chosen combination of attributes that pulls against the ranking, for example a multicast frame that also carries an Ethernet type, or a flow-control type with an illegal length.

// File: rtl/fse_pkg.sv
package fse_pkg;
  localparam logic [2:0] ST_OK      = 3'd0;
  localparam logic [2:0] ST_ETYPE   = 3'd1;
  localparam logic [2:0] ST_MCAST   = 3'd2;
  localparam logic [2:0] ST_PTP     = 3'd3;
  localparam logic [2:0] ST_FCFLAG  = 3'd4;
  localparam logic [2:0] ST_STACKED = 3'd5;
  localparam logic [2:0] ST_BADLEN  = 3'd6;
  localparam logic [2:0] ST_PAUSE   = 3'd7;

  localparam logic [15:0] TPID_C   = 16'h8100;
  localparam logic [15:0] TPID_S   = 16'h88A8;
  localparam logic [15:0] LT_PAUSE = 16'h8808;
  localparam logic [15:0] LT_PTP   = 16'h88F7;
  localparam logic [15:0] LT_MINET = 16'h0600;

  typedef struct packed {
    logic stacked;
    logic fc_flag;
    logic pause;
    logic bad_len;
    logic etype;
    logic mcast;
    logic ptp;
    logic ok_len;
  } fse_attr_t;
endpackage

// File: rtl/fse_hdr_parse.sv
module fse_hdr_parse #(
  parameter int MAX_TAGS = 2,
  parameter int LT_POS   = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_sof,
  input  logic [7:0]  in_data,
  output logic        mcast_n,
  output logic        stacked_n,
  output logic        lt_done_n,
  output logic [15:0] lt_n
);
  import fse_pkg::*;

  localparam int HDR_MAX = LT_POS + 4 * MAX_TAGS + 2;
  localparam int CNT_W   = $clog2(HDR_MAX + 1) + 1;
  localparam int TAG_W   = $clog2(MAX_TAGS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_b, cnt_d, pos_q, pos_b, pos_d;
  logic [TAG_W-1:0] tags_q, tags_b, tags_d;
  logic             sv_q, sv_b, mc_q, mc_b, done_q, done_b;
  logic [7:0]       hi_q, hi_d;
  logic [15:0]      lt_q, lt_b, word;

  always_comb begin
    cnt_b  = in_sof ? '0 : cnt_q;
    pos_b  = in_sof ? CNT_W'(LT_POS) : pos_q;
    tags_b = in_sof ? '0 : tags_q;
    sv_b   = in_sof ? 1'b0 : sv_q;
    mc_b   = in_sof ? 1'b0 : mc_q;
    done_b = in_sof ? 1'b0 : done_q;
    lt_b   = in_sof ? '0 : lt_q;
    word   = {hi_q, in_data};

    cnt_d     = (cnt_b == CNT_MAX) ? cnt_b : cnt_b + 1'b1;
    pos_d     = pos_b;
    tags_d    = tags_b;
    hi_d      = hi_q;
    mcast_n   = mc_b;
    stacked_n = sv_b;
    lt_done_n = done_b;
    lt_n      = lt_b;

    if (cnt_b == '0) mcast_n = in_data[0];
    if (!done_b && cnt_b == pos_b) hi_d = in_data;
    if (!done_b && cnt_b == pos_b + 1'b1) begin
      if ((word == TPID_C || word == TPID_S) && tags_b < TAG_W'(MAX_TAGS)) begin
        tags_d = tags_b + 1'b1;
        pos_d  = pos_b + CNT_W'(4);
        if ((word == TPID_S && tags_b == '0) || tags_b != '0) stacked_n = 1'b1;
      end else begin
        lt_n      = word;
        lt_done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pos_q  <= CNT_W'(LT_POS);
      tags_q <= '0;
      sv_q   <= 1'b0;
      mc_q   <= 1'b0;
      done_q <= 1'b0;
      hi_q   <= '0;
      lt_q   <= '0;
    end else if (in_valid) begin
      cnt_q  <= cnt_d;
      pos_q  <= pos_d;
      tags_q <= tags_d;
      sv_q   <= stacked_n;
      mc_q   <= mcast_n;
      done_q <= lt_done_n;
      hi_q   <= hi_d;
      lt_q   <= lt_n;
    end
  end

  // R2: tag count never exceeds the configured depth
  a_r2_tag_limit: assert property (@(posedge clk) disable iff (!rst_n)
    tags_q <= TAG_W'(MAX_TAGS));

  // R10 / R11: a resolved type is frozen until a new frame starts
  a_r10_lt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !(in_valid && in_sof)) |=> (lt_q == $past(lt_q)));
endmodule

// File: rtl/fse_prio_enc.sv
module fse_prio_enc (
  input  fse_pkg::fse_attr_t attr,
  output logic [2:0]         code
);
  import fse_pkg::*;

  always_comb begin
    if      (attr.stacked) code = ST_STACKED;
    else if (attr.fc_flag) code = ST_FCFLAG;
    else if (attr.pause)   code = ST_PAUSE;
    else if (attr.bad_len) code = ST_BADLEN;
    else if (attr.etype)   code = ST_ETYPE;
    else if (attr.mcast)   code = ST_MCAST;
    else if (attr.ptp)     code = ST_PTP;
    else                   code = ST_OK;
  end
endmodule

// File: rtl/frame_status_enc.sv
module frame_status_enc #(
  parameter int MAX_TAGS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_sof,
  input  logic       in_eof,
  input  logic [7:0] in_data,
  input  logic       in_len_ok,
  input  logic       in_fc_flag,
  output logic       stat_valid,
  output logic [2:0] stat_code
);
  import fse_pkg::*;

  logic        mcast, stacked, lt_done;
  logic [15:0] lt;
  fse_attr_t   attr;
  logic [2:0]  code_d, code_q;
  logic        vld_d, vld_q, eof_beat;

  fse_hdr_parse #(.MAX_TAGS(MAX_TAGS), .LT_POS(12)) u_parse (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_sof   (in_sof),
    .in_data  (in_data),
    .mcast_n  (mcast),
    .stacked_n(stacked),
    .lt_done_n(lt_done),
    .lt_n     (lt)
  );

  always_comb begin
    attr.stacked = stacked;
    attr.fc_flag = in_fc_flag;
    attr.pause   = lt_done && (lt == LT_PAUSE);
    attr.bad_len = !in_len_ok;
    attr.ptp     = lt_done && (lt == LT_PTP);
    attr.etype   = lt_done && (lt >= LT_MINET) && (lt != LT_PAUSE) && (lt != LT_PTP);
    attr.mcast   = mcast;
    attr.ok_len  = in_len_ok;
  end

  fse_prio_enc u_prio (.attr(attr), .code(code_d));

  assign eof_beat = in_valid && in_eof;
  assign vld_d    = eof_beat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      code_q <= ST_OK;
    end else begin
      vld_q <= vld_d;
      if (eof_beat) code_q <= code_d;
    end
  end

  assign stat_valid = vld_q;
  assign stat_code  = code_q;

  a_r1_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> $past(in_valid && in_eof));

  a_r2_stacked_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (eof_beat && stacked) |=> (stat_code == ST_STACKED));

  a_r3_fc_next: assert property (@(posedge clk) disable iff (!rst_n)
    (eof_beat && in_fc_flag && !stacked) |=> (stat_code == ST_FCFLAG));

  a_r5_ok_needs_len: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && stat_code == ST_OK) |-> $past(in_len_ok));
endmodule

// File: tb/tb_frame_status_enc.sv
module tb_frame_status_enc;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_sof, in_eof, in_len_ok, in_fc_flag;
  logic [7:0] in_data;
  logic       stat_valid;
  logic [2:0] stat_code;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [7:0] fr [0:63];
  int fl;

  always #2.5 clk = ~clk;

  frame_status_enc dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_data(in_data), .in_len_ok(in_len_ok),
    .in_fc_flag(in_fc_flag), .stat_valid(stat_valid), .stat_code(stat_code)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic build(input logic [7:0] da0, input logic [15:0] t1, input logic [15:0] t2,
                       input logic [15:0] lt, input int nbytes);
    int p;
    for (int i = 0; i < 64; i++) fr[i] = 8'h20 + 8'(i);
    fr[0] = da0;
    p = 12;
    if (t1 != 0) begin
      fr[p] = t1[15:8]; fr[p+1] = t1[7:0]; fr[p+2] = 8'h00; fr[p+3] = 8'h05; p += 4;
    end
    if (t2 != 0) begin
      fr[p] = t2[15:8]; fr[p+1] = t2[7:0]; fr[p+2] = 8'h00; fr[p+3] = 8'h07; p += 4;
    end
    fr[p] = lt[15:8]; fr[p+1] = lt[7:0];
    fl = nbytes;
  endtask

  task automatic send(input string req, input logic [2:0] exp, input logic len_ok,
                      input logic fc, input bit bubbles);
    for (int i = 0; i < fl; i++) begin
      if (bubbles) begin
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'h81;
        in_len_ok = 1'b0; in_fc_flag = 1'b1;
      end
      @(negedge clk);
      in_valid   = 1'b1;
      in_sof     = (i == 0);
      in_eof     = (i == fl - 1);
      in_data    = fr[i];
      in_len_ok  = (i == fl - 1) ? len_ok : 1'b0;
      in_fc_flag = (i == fl - 1) ? fc : 1'b1;
      if (i > 0) check({req, " R1 no strobe mid-frame"}, {3'b0, stat_valid}, 4'd0);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_fc_flag = 1'b0; in_len_ok = 1'b1;
    check({req, " R1 strobe"}, {3'b0, stat_valid}, 4'd1);
    check({req, " code"}, {1'b0, stat_code}, {1'b0, exp});
    @(negedge clk);
    check({req, " R1 strobe drops"}, {3'b0, stat_valid}, 4'd0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    in_data = '0; in_len_ok = 1'b0; in_fc_flag = 1'b0;
    repeat (3) @(negedge clk);
    check("R13 in reset", {3'b0, stat_valid}, 4'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R13 after reset", {3'b0, stat_valid}, 4'd0);
  endtask

  task automatic t_basic;
    build(8'h00, 0, 0, 16'h002E, 64); send("R9 plain unicast", 3'd0, 1, 0, 0);
    build(8'h00, 0, 0, 16'h002E, 64); send("R5 illegal length", 3'd6, 0, 0, 0);
    build(8'h01, 0, 0, 16'h0040, 64); send("R7 multicast", 3'd2, 1, 0, 0);
    build(8'hFF, 0, 0, 16'h0040, 64); send("R7 broadcast", 3'd2, 1, 0, 0);
  endtask

  task automatic t_types;
    build(8'h00, 0, 0, 16'h0800, 64); send("R6 ethertype", 3'd1, 1, 0, 0);
    build(8'h01, 0, 0, 16'h0600, 64); send("R6 over multicast", 3'd1, 1, 0, 0);
    build(8'h00, 0, 0, 16'h05FF, 64); send("R9 below 0x0600", 3'd0, 1, 0, 0);
    build(8'h00, 0, 0, 16'h88F7, 64); send("R8 ptp", 3'd3, 1, 0, 0);
    build(8'h01, 0, 0, 16'h88F7, 64); send("R8 ptp under multicast", 3'd2, 1, 0, 0);
    build(8'h00, 0, 0, 16'h8808, 64); send("R4 pause", 3'd7, 1, 0, 0);
    build(8'h00, 0, 0, 16'h8808, 64); send("R4 pause over bad length", 3'd7, 0, 0, 0);
    build(8'h01, 0, 0, 16'h8808, 64); send("R3 fc flag over pause", 3'd4, 0, 1, 0);
  endtask

  task automatic t_tags;
    build(8'h00, 16'h88A8, 16'h8100, 16'h0800, 64); send("R2 s-tag stack over fc", 3'd5, 0, 1, 0);
    build(8'h00, 16'h8100, 16'h8100, 16'h8808, 64); send("R2 double c-tag", 3'd5, 1, 0, 0);
    build(8'h00, 16'h88A8, 0, 16'h0040, 64); send("R2 single s-tag", 3'd5, 1, 0, 0);
    build(8'h00, 16'h8100, 0, 16'h88F7, 64); send("R10 tag skipped to ptp", 3'd3, 1, 0, 0);
    build(8'h00, 16'h8100, 0, 16'h0040, 64); send("R10 tag not a type", 3'd0, 1, 0, 0);
  endtask

  task automatic t_edges;
    build(8'h00, 0, 0, 16'h8808, 30); send("R11 bubbles ignored", 3'd7, 1, 0, 1);
    build(8'h01, 0, 0, 16'h0800, 13); send("R12 short multicast", 3'd2, 1, 0, 0);
    build(8'h00, 0, 0, 16'h8808, 10); send("R12 short bad length", 3'd6, 0, 0, 0);
    build(8'h00, 0, 0, 16'h0800, 13); send("R12 short unicast", 3'd0, 1, 0, 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_types();
    t_tags();
    t_edges();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule